// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Lanes

This block is a clocked single-port memory that accepts one command on every rising clock edge on which its stall input is low. A command either loads a new external address and starts a read or a write, continues a burst from an internally advanced address, or deselects the memory. A burst continuation repeats the kind of access that came before it. The two low address bits step through four beats, in either wrap-around counting order or XOR order. The upper address bits stay as loaded.

Write data follows its command by two accepted edges. This lets a controller issue addresses back to back while the data bus trails behind. Read data is registered and appears after the accepted edge that follows the read command. A read that hits a write whose data is still in flight returns the merged data, so a controller never sees stale contents. Each 16-bit word is split into two byte lanes, and each lane carries one parity bit. An active-low select per lane masks the write.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted, and after it, until a read reaches the output, `drive_o` is 0 whatever `oe_ni` shows.
- R2: An edge with `stall_i` = 1 changes nothing: no address, burst position, pipeline stage or output register advances. A burst interrupted by stalls continues with the beat it would have taken next.
- R3: An edge with `stall_i` = 0, `adv_i` = 0 and `sel_ni` = 1 is a deselect. After the next accepted edge, `drive_o` is 0.
- R4: An edge with `stall_i` = 0, `adv_i` = 0, `sel_ni` = 0 and `wr_ni` = 1 loads `addr_i` and reads it. After the next accepted edge, `rdata_o`/`rpar_o` hold that word and `drive_o` = 1 while `oe_ni` = 0.
- R5: An edge with `adv_i` = 0, `sel_ni` = 0 and `wr_ni` = 0 loads `addr_i` for a write. The word is taken from `wdata_i`/`wpar_i` on the second accepted edge after the command edge.
- R6: An accepted edge with `adv_i` = 1 repeats the kind of the previous access (read, write or deselect), whatever `sel_ni` and `wr_ni` show. `bw_ni` is sampled on every write beat.
- R7: With `ilv_i` = 0 at the load, beat n of a burst uses low address bits (start + n) mod 4.
- R8: With `ilv_i` = 1 at the load, beat n uses low bits start XOR n. `ilv_i` is ignored on continuation edges.
- R9: `bw_ni[0]` = 0 enables `wdata_i[7:0]` and `wpar_i[0]`. `bw_ni[1]` = 0 enables `wdata_i[15:8]` and `wpar_i[1]`. With `bw_ni` = 2'b11, the write leaves the word unchanged.
- R10: `drive_o` is 0 whenever `oe_ni` = 1, even in a read data cycle.
- R11: A read whose command directly follows a write to the same address returns the written, lane-masked word.
- R12: During a burst, address bits above bit 1 keep their loaded value. The beat count wraps after four beats and continues while `adv_i` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | 1 = wait state; the edge is ignored |
| sel_ni | input | 1 | Active-low chip select for load cycles |
| adv_i | input | 1 | 1 = continue burst, 0 = load or deselect |
| wr_ni | input | 1 | 0 = write, 1 = read on a load |
| bw_ni | input | LANES (2) | Active-low byte lane write selects |
| ilv_i | input | 1 | Burst order at load: 1 XOR, 0 linear |
| oe_ni | input | 1 | Active-low output enable |
| addr_i | input | AW (8) | Word address |
| wdata_i | input | DW (16) | Write data, two accepted edges after its command |
| wpar_i | input | LANES (2) | Write parity, one bit per lane |
| rdata_o | output | DW (16) | Registered read data |
| rpar_o | output | LANES (2) | Registered read parity |
| drive_o | output | 1 | Output data valid / pad drive flag |

## Verification
The hardest case to reach is one where the write pipeline, the read register and the burst counter are all mid-flight while stalls freeze them. Examples are a write burst whose data trails by two accepted edges with stall cycles wedged between beats, and a read of a word whose data is presented on the same edge. The bench reaches these states with a reference model that advances only on accepted edges and supplies each write's data from its own record of the access two accepted edges back. Stalls can therefore be inserted anywhere, and every beat is still checked. Sweeps across every start address in both burst orders cover all wrap points.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2
   } acc_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
   import sbs_pkg::*;
(
   input  logic sel_ni,
   input  logic adv_i,
   input  logic wr_ni,
   input  acc_e last_i,
   output logic load_o,
   output acc_e acc_o
);
   always_comb begin
      load_o = 1'b0;
      acc_o  = ACC_IDLE;
      if (adv_i) begin
         acc_o = last_i;               // continuation inherits kind
      end else if (!sel_ni) begin
         load_o = 1'b1;
         acc_o  = wr_ni ? ACC_RD : ACC_WR;
      end
   end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
   parameter int AW         = 8,
   parameter int BURST_BITS = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic          load_i,
   input  logic          adv_i,
   input  logic          ilv_i,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] cur_addr_o
);
   localparam int HW = AW - BURST_BITS;

   logic [HW-1:0]         hi_q;
   logic [BURST_BITS-1:0] base_q, cnt_q, cnt_nx, ord;
   logic                  ilv_q;

   assign cnt_nx = cnt_q + 1'b1;
   assign ord    = ilv_q ? (base_q ^ cnt_nx) : (base_q + cnt_nx);
   assign cur_addr_o = load_i ? addr_i : {hi_q, ord};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q   <= '0;
         base_q <= '0;
         cnt_q  <= '0;
         ilv_q  <= 1'b0;
      end else if (en_i) begin
         if (load_i) begin
            hi_q   <= addr_i[AW-1:BURST_BITS];
            base_q <= addr_i[BURST_BITS-1:0];
            cnt_q  <= '0;
            ilv_q  <= ilv_i;
         end else if (adv_i) begin
            cnt_q  <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
   parameter int DEPTH = 256,
   parameter int W     = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o
);
   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o <= '0;
      end else if (re_i) begin
         rdata_o <= (we_i && (waddr_i == raddr_i)) ? wdata_i : mem_q[raddr_i];
      end
   end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import sbs_pkg::*;
#(
   parameter int DEPTH      = 256,
   parameter int LANE_W     = 8,
   parameter int LANES      = 2,
   parameter int BURST_BITS = 2,
   localparam int AW        = $clog2(DEPTH),
   localparam int DW        = LANES * LANE_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             stall_i,
   input  logic             sel_ni,
   input  logic             adv_i,
   input  logic             wr_ni,
   input  logic [LANES-1:0] bw_ni,
   input  logic             ilv_i,
   input  logic             oe_ni,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [LANES-1:0] wpar_i,
   output logic [DW-1:0]    rdata_o,
   output logic [LANES-1:0] rpar_o,
   output logic             drive_o
);
   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("burst_sram: DEPTH must be a power of two");
   end
   if (AW <= BURST_BITS) begin : g_bad_span
      $error("burst_sram: DEPTH must exceed one burst");
   end
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lane
      $error("burst_sram: lane geometry must be non-empty");
   end

   logic             valid;
   logic             load;
   acc_e             acc, s1_acc;
   logic [AW-1:0]    cur_addr, s1_addr, s2_addr;
   logic [LANES-1:0] s1_bw, s2_bw;
   logic             s2_wr, drv_q;

   assign valid = ~stall_i;

   sbs_cmd_decode u_dec (
      .sel_ni (sel_ni),
      .adv_i  (adv_i),
      .wr_ni  (wr_ni),
      .last_i (s1_acc),
      .load_o (load),
      .acc_o  (acc)
   );

   sbs_burst_seq #(.AW(AW), .BURST_BITS(BURST_BITS)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (valid),
      .load_i     (load),
      .adv_i      (adv_i),
      .ilv_i      (ilv_i),
      .addr_i     (addr_i),
      .cur_addr_o (cur_addr)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_acc  <= ACC_IDLE;
         s1_addr <= '0;
         s1_bw   <= '1;
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_bw   <= '1;
         drv_q   <= 1'b0;
      end else if (valid) begin
         s1_acc  <= acc;
         s1_addr <= cur_addr;
         s1_bw   <= bw_ni;
         s2_wr   <= (s1_acc == ACC_WR);
         s2_addr <= s1_addr;
         s2_bw   <= s1_bw;
         drv_q   <= (s1_acc == ACC_RD);
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W:0] rd_word;
      sbs_lane_mem #(.DEPTH(DEPTH), .W(LANE_W + 1)) u_mem (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .we_i    (valid & s2_wr & ~s2_bw[l]),
         .waddr_i (s2_addr),
         .wdata_i ({wpar_i[l], wdata_i[l*LANE_W +: LANE_W]}),
         .re_i    (valid & (s1_acc == ACC_RD)),
         .raddr_i (s1_addr),
         .rdata_o (rd_word)
      );
      assign rdata_o[l*LANE_W +: LANE_W] = rd_word[LANE_W-1:0];
      assign rpar_o[l]                   = rd_word[LANE_W];
   end

   assign drive_o = drv_q & ~oe_ni;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          stall_i,
   input logic          adv_i,
   input logic          oe_ni,
   input logic          drive_o,
   input logic [DW-1:0] rdata_o,
   input logic [1:0]    s1_acc,
   input logic [AW-1:0] s1_addr,
   input logic          s2_wr
);
   a_r1_reset_quiet: assert property (@(posedge clk_i)
      !rst_ni |-> !drive_o);

   a_r2_stall_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i |=> $stable(rdata_o));

   a_r3_idle_stage_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && s1_acc == 2'd0) |=> !drive_o);

   a_r4_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && s1_acc == 2'd1) |=> (drive_o || oe_ni));

   a_r5_write_enters_stage2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && s1_acc == 2'd2) |=> s2_wr);

   a_r6_burst_inherits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && adv_i) |=> s1_acc == $past(s1_acc));

   a_r12_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && adv_i) |=> s1_addr[AW-1:2] == $past(s1_addr[AW-1:2]));
endmodule

bind burst_sram burst_sram_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .stall_i (stall_i),
   .adv_i   (adv_i),
   .oe_ni   (oe_ni),
   .drive_o (drive_o),
   .rdata_o (rdata_o),
   .s1_acc  (s1_acc),
   .s1_addr (s1_addr),
   .s2_wr   (s2_wr)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb_top;
   localparam int DEPTH = 256;
   localparam int AW    = 8;

   logic        clk = 1'b0;
   logic        rst_ni;
   logic        stall_i, sel_ni, adv_i, wr_ni, ilv_i, oe_ni;
   logic [1:0]  bw_ni, wpar_i, rpar_o;
   logic [AW-1:0] addr_i;
   logic [15:0] wdata_i, rdata_o;
   logic        drive_o;

   always #5 clk = ~clk;

   burst_sram dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall_i), .sel_ni(sel_ni),
      .adv_i(adv_i), .wr_ni(wr_ni), .bw_ni(bw_ni), .ilv_i(ilv_i),
      .oe_ni(oe_ni), .addr_i(addr_i), .wdata_i(wdata_i), .wpar_i(wpar_i),
      .rdata_o(rdata_o), .rpar_o(rpar_o), .drive_o(drive_o)
   );

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] salt = 8'h00;

   // reference model, advanced only on accepted edges
   logic [15:0] md [DEPTH];
   logic [1:0]  mp [DEPTH];
   int          prv_acc = 0, w2_acc = 0;   // 0 idle, 1 read, 2 write
   logic [7:0]  prv_addr = 0, w2_addr = 0;
   logic [1:0]  prv_bw = 2'b11, w2_bw = 2'b11;
   logic [5:0]  m_hi = 0;
   logic [1:0]  m_base = 0, m_cnt = 0;
   logic        m_ilv = 0;
   logic        exp_drv = 0;
   logic [15:0] exp_d = 0;
   logic [1:0]  exp_p = 0;

   function automatic logic [15:0] pat(input logic [7:0] a);
      return {a ^ salt, (a * 8'd7) + salt};
   endfunction

   function automatic logic [1:0] ppat(input logic [7:0] a);
      return a[1:0] ^ salt[3:2] ^ a[3:2];
   endfunction

   task automatic check_eq(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_edge(input logic sel_n, input logic adv, input logic wr_n,
                             input logic [1:0] bw, input logic ilv, input logic [7:0] a);
      int acc;
      logic [7:0] cur;
      if (w2_acc == 2) begin
         for (int l = 0; l < 2; l++) begin
            if (!w2_bw[l]) begin
               md[w2_addr][l*8 +: 8] = wdata_i[l*8 +: 8];
               mp[w2_addr][l]        = wpar_i[l];
            end
         end
      end
      if (prv_acc == 1) begin
         exp_d = md[prv_addr]; exp_p = mp[prv_addr]; exp_drv = 1'b1;
      end else begin
         exp_drv = 1'b0;
      end
      w2_acc = prv_acc; w2_addr = prv_addr; w2_bw = prv_bw;
      cur = prv_addr;
      if (adv) begin
         m_cnt = m_cnt + 2'd1;
         cur = {m_hi, (m_ilv ? (m_base ^ m_cnt) : (m_base + m_cnt))};
         acc = prv_acc;
      end else if (sel_n) begin
         acc = 0;
      end else begin
         m_hi = a[7:2]; m_base = a[1:0]; m_cnt = 2'd0; m_ilv = ilv;
         acc = wr_n ? 1 : 2;
         cur = a;
      end
      prv_acc = acc; prv_addr = cur; prv_bw = bw;
   endtask

   task automatic step(input string tag, input logic st, input logic sel_n,
                       input logic adv, input logic wr_n, input logic [1:0] bw,
                       input logic ilv, input logic oe_n, input logic [7:0] a);
      stall_i = st; sel_ni = sel_n; adv_i = adv; wr_ni = wr_n;
      bw_ni = bw; ilv_i = ilv; oe_ni = oe_n; addr_i = a;
      if (w2_acc == 2) begin
         wdata_i = pat(w2_addr); wpar_i = ppat(w2_addr);
      end else begin
         wdata_i = 16'h0; wpar_i = 2'b00;
      end
      @(posedge clk);
      if (!st) model_edge(sel_n, adv, wr_n, bw, ilv, a);
      #3;
      check_eq(tag, "drive", {31'd0, drive_o}, {31'd0, exp_drv & ~oe_n});
      if (exp_drv)
         check_eq(tag, "data", {14'd0, rpar_o, rdata_o}, {14'd0, exp_p, exp_d});
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_ni = 1'b0; stall_i = 1'b0; sel_ni = 1'b1; adv_i = 1'b0; wr_ni = 1'b1;
      bw_ni = 2'b11; ilv_i = 1'b0; oe_ni = 1'b0; addr_i = '0;
      wdata_i = '0; wpar_i = '0;
      repeat (3) @(posedge clk);
      #3;
      check_eq("R1", "drive in reset", {31'd0, drive_o}, 32'd0);
      rst_ni = 1'b1;
      idle("R1");

      // R5: fill every word with single writes
      salt = 8'h11;
      for (int a = 0; a < DEPTH; a++)
         step("R5", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, a[7:0]);
      idle("R5"); idle("R5");

      // R4 single reads, R3 deselect between them
      for (int a = 0; a < 16; a++) begin
         step("R4", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'(a * 13));
         idle("R3");
         idle("R3");
      end

      // R7 linear bursts from every start, continuation shows noise on sel/wr (R6)
      for (int s = 0; s < DEPTH; s++) begin
         step("R7", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, s[7:0]);
         for (int b = 1; b < 4; b++)
            step("R7", 1'b0, b[0], 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 8'hFF);
      end
      idle("R7");

      // R8 interleaved bursts, mode input flipped during continuation
      for (int s = 0; s < DEPTH; s++) begin
         step("R8", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, s[7:0]);
         for (int b = 1; b < 4; b++)
            step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00);
      end
      idle("R8");

      // R12 long linear burst wraps and keeps upper bits
      step("R12", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'hA6);
      for (int b = 1; b < 9; b++)
         step("R12", 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00);
      idle("R12");

      // R2 write burst with stalls between beats, read wr_n=1 on beats (R6)
      salt = 8'h5A;
      step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h80);
      for (int b = 1; b < 8; b++) begin
         step("R2", 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00);
         step("R6", 1'b0, 1'b1, 1'b1, 1'b1, b[0] ? 2'b10 : 2'b00, 1'b0, 1'b0, 8'h00);
      end
      step("R2", 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00);
      idle("R2"); step("R2", 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00);
      idle("R2");
      // read it back interleaved with stalls
      step("R2", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 8'h81);
      for (int b = 1; b < 8; b++) begin
         step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00);
         step("R2", 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00);
      end
      step("R2", 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00);
      idle("R2");

      // R9 lane masks
      salt = 8'hC3;
      step("R9", 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 8'h10);
      step("R9", 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'h11);
      step("R9", 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 8'h12);
      idle("R9"); idle("R9");
      for (int a = 16; a < 19; a++)
         step("R9", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, a[7:0]);
      idle("R9");

      // R11 read right behind a write, then two writes and two reads
      salt = 8'h77;
      step("R11", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h20);
      step("R11", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h20);
      step("R11", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h20);
      step("R11", 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'h21);
      step("R11", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h22);
      step("R11", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h21);
      step("R11", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h22);
      idle("R11"); idle("R11");

      // R10 output enable high blocks drive in a data cycle
      step("R10", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'h05);
      step("R10", 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 8'h00);
      idle("R10");

      // R6 burst after deselect stays idle and writes nothing
      idle("R6");
      for (int b = 0; b < 4; b++)
         step("R6", 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00);
      idle("R6"); idle("R6");
      for (int a = 0; a < 4; a++)
         step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, a[7:0]);
      idle("R6");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule